// File: doc/BRIEF.md
# Zero-Voltage-Switching Full-Bridge Gate Sequencer

This block turns a system clock into the switching pattern of a phase-shifted full bridge. It drives the high-side and low-side gate commands of two bridge legs, A and B, and the two synchronous-rectifier commands. Time is kept in system-clock cycles. A switching period is made of two equal phases of `P` cycles, phase 0 and then phase 1. Each phase opens with a dead-time window of `D` cycles. The high-side commands run at a fixed duty and are complementary. A low-side command turns on `R` cycles after the high side of its own leg turns off. It turns off at the end of its phase, or earlier when the current-mode comparator trips. For `B` cycles after a low side turns on, comparator trips are masked, so that switching spikes cannot end the pulse.

The comparator trip and the peak-current trip arrive as synchronous single-bit inputs. A peak trip ends the low-side pulse at once, and that pulse stays off for the rest of the phase. The four timing settings are sampled only when the block is enabled and at the end of phase 1. A register written in the middle of a period therefore cannot distort the pattern already under way. When `enable` falls, all outputs go low in the same cycle.

The sequencer is a six-state machine with a cycle counter `t` inside the phase and a phase bit:
- IDLE: outputs off. It moves to DEAD when enabled.
- DEAD: covers `t < D`. It moves to RES at `t = D`.
- RES: the resonant wait. It moves to BLANK, or to ON when `B = 0`, at `t = D+R`.
- BLANK: low side on, comparator trip masked. It moves to ON at `t = D+R+B`, or to DONE on a peak trip.
- ON: low side on. It moves to DONE on either trip.
- DONE: the pulse has ended and the machine waits for the phase end.

From every running state, the last cycle `t = P-1` returns to DEAD with the phase flipped. `enable` low returns the machine to IDLE.

Top module: `zvs_bridge_seq`

## Requirements
- R1: After enable, the phases alternate, each `P` cycles long, starting with phase 0. `sr_a` is high for all of phase 0 and `sr_b` for all of phase 1. Each rises at the start of its phase and falls one dead time before the high side of its leg turns off.
- R2: `hi_a` is high from cycle `D` of phase 0 up to cycle `D` of phase 1, and `hi_b` is its complement. Neither trip input ever changes them.
- R3: `lo_a` (in phase 1) and `lo_b` (in phase 0) turn on at cycle `D+R` of their phase, `R` cycles after their own leg's high side turns off.
- R4: `hi_a` and `lo_a` are never high together, nor are `hi_b` and `lo_b`. A low side is off at least `D` cycles before its leg's high side turns on.
- R5: With no trip, a low side stays on through the last cycle `P-1` of its phase. A `pwm_trip` seen in cycle `t >= D+R+B` while the low side is on leaves it high in `t` and low from `t+1` to the end of the phase.
- R6: `blank_active` is high in cycles `D+R` to `D+R+B-1` of the pulse. `pwm_trip` is ignored there and during dead time and the resonant wait. With `B = 0` there is no blanking.
- R7: `peak_trip` drives the active low side low in the same cycle, without blanking. The low side stays low until the next phase.
- R8: The period, dead-time, resonant and blanking settings are taken only on the enabling cycle and at the last cycle of phase 1. Changes at other times take effect from the next phase 0.
- R9: `enable` low forces all seven outputs low in the same cycle. On re-enable the block restarts at phase 0, cycle 0.
- R10: Dead time or resonant delay programmed as 0 act as 1. A period below 2 acts as 2.
- R11: While reset is asserted, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Run command. Low forces all outputs off |
| cfg_period | input | CNT_W | Phase length in cycles |
| cfg_dead | input | CNT_W | Dead time in cycles |
| cfg_resdly | input | CNT_W | Resonant delay in cycles |
| cfg_blank | input | CNT_W | Blanking window in cycles, 0 disables it |
| pwm_trip | input | 1 | Current-mode comparator trip |
| peak_trip | input | 1 | Peak-current limit trip |
| hi_a | output | 1 | Leg A high-side gate command |
| hi_b | output | 1 | Leg B high-side gate command |
| lo_a | output | 1 | Leg A low-side gate command |
| lo_b | output | 1 | Leg B low-side gate command |
| sr_a | output | 1 | Synchronous rectifier command, phase 0 |
| sr_b | output | 1 | Synchronous rectifier command, phase 1 |
| blank_active | output | 1 | Trip masking window is open |

## Verification
The assertions assume that both trips and `enable` are synchronous to `clk` and held stable across each rising edge. They also assume that the settings may change at any cycle, because the block, not its driver, is responsible for sampling them. The bench drives every input, settings included, only at the falling edge. It draws trips and setting writes from a seeded generator, with settings kept small enough that dead time, resonant wait and blanking often cover the whole phase. Directed runs add zero settings, a permanently asserted trip and enable toggling.

// File: rtl/zvs_seq_pkg.sv
package zvs_seq_pkg;
    // Sequencer states inside one bridge phase
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DEAD,
        ST_RES,
        ST_BLANK,
        ST_ON,
        ST_DONE
    } seq_state_e;

    localparam int MIN_PERIOD = 2;
    localparam int MIN_DELAY  = 1;
endpackage

// File: rtl/zvs_cfg_latch.sv
module zvs_cfg_latch #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] cfg_period,
    input  logic [CNT_W-1:0] cfg_dead,
    input  logic [CNT_W-1:0] cfg_resdly,
    input  logic [CNT_W-1:0] cfg_blank,
    output logic [CNT_W-1:0] per_q,
    output logic [CNT_W-1:0] dead_q,
    output logic [CNT_W-1:0] res_q,
    output logic [CNT_W-1:0] blank_q
);
    localparam logic [CNT_W-1:0] MINP = CNT_W'(zvs_seq_pkg::MIN_PERIOD);
    localparam logic [CNT_W-1:0] MIND = CNT_W'(zvs_seq_pkg::MIN_DELAY);

    // Settings are clamped when sampled (R10) and held between loads (R8)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            per_q   <= MINP;
            dead_q  <= MIND;
            res_q   <= MIND;
            blank_q <= '0;
        end else if (load) begin
            per_q   <= (cfg_period < MINP) ? MINP : cfg_period;
            dead_q  <= (cfg_dead   < MIND) ? MIND : cfg_dead;
            res_q   <= (cfg_resdly < MIND) ? MIND : cfg_resdly;
            blank_q <= cfg_blank;
        end
    end
endmodule

// File: rtl/zvs_phase_fsm.sv
module zvs_phase_fsm
    import zvs_seq_pkg::*;
#(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             pwm_trip,
    input  logic             peak_trip,
    input  logic [CNT_W-1:0] per_q,
    input  logic [CNT_W-1:0] dead_q,
    input  logic [CNT_W-1:0] res_q,
    input  logic [CNT_W-1:0] blank_q,
    output seq_state_e       state_q,
    output logic             phase_q,
    output logic             load
);
    localparam int SW = CNT_W + 2;

    logic [CNT_W-1:0] cnt_q, cnt_d;
    seq_state_e       st_d;
    logic             ph_d;
    logic [SW-1:0]    cnt_x, per_x, dead_x, lo_start, blk_end;
    logic             last;

    assign cnt_x    = {2'b00, cnt_q};
    assign per_x    = {2'b00, per_q};
    assign dead_x   = {2'b00, dead_q};
    assign lo_start = dead_x + {2'b00, res_q};
    assign blk_end  = lo_start + {2'b00, blank_q};
    assign last     = (cnt_x == per_x - SW'(1));

    // Settings are taken on the enabling cycle and at the end of phase 1
    assign load = enable && ((state_q == ST_IDLE) || (phase_q && last));

    always_comb begin
        st_d  = state_q;
        cnt_d = cnt_q;
        ph_d  = phase_q;
        if (!enable) begin
            st_d  = ST_IDLE;
            cnt_d = '0;
            ph_d  = 1'b0;
        end else if (state_q == ST_IDLE) begin
            st_d  = ST_DEAD;
            cnt_d = '0;
            ph_d  = 1'b0;
        end else if (last) begin
            st_d  = ST_DEAD;
            cnt_d = '0;
            ph_d  = ~phase_q;
        end else begin
            cnt_d = cnt_q + CNT_W'(1);
            unique case (state_q)
                ST_DEAD:  if (cnt_x == dead_x - SW'(1)) st_d = ST_RES;
                ST_RES:   if (cnt_x == lo_start - SW'(1))
                              st_d = (blank_q == '0) ? ST_ON : ST_BLANK;
                ST_BLANK: begin
                    if (peak_trip)                       st_d = ST_DONE;
                    else if (cnt_x == blk_end - SW'(1))  st_d = ST_ON;
                end
                ST_ON:    if (peak_trip || pwm_trip)     st_d = ST_DONE;
                ST_IDLE, ST_DONE: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            phase_q <= 1'b0;
        end else begin
            state_q <= st_d;
            cnt_q   <= cnt_d;
            phase_q <= ph_d;
        end
    end

    AST_PHASE_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && state_q != ST_IDLE && last) |=>
        (cnt_q == '0 && phase_q != $past(phase_q) && state_q == ST_DEAD)); // R1
    AST_PEAK_ENDS_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && peak_trip && (state_q == ST_BLANK || state_q == ST_ON) && !last)
        |=> state_q == ST_DONE); // R7
    AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && state_q != ST_IDLE && !(phase_q && last)) |=>
        ($stable(per_q) && $stable(dead_q) && $stable(res_q) && $stable(blank_q))); // R8
    AST_DISABLE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> state_q == ST_IDLE); // R9
endmodule

// File: rtl/zvs_gate_decode.sv
module zvs_gate_decode
    import zvs_seq_pkg::*;
#(
    parameter int NLEG = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            enable,
    input  logic            peak_trip,
    input  seq_state_e      state_q,
    input  logic            phase_q,
    input  logic            blank_nz,
    output logic [NLEG-1:0] hi,
    output logic [NLEG-1:0] lo,
    output logic [NLEG-1:0] sr,
    output logic            blank_active
);
    logic run, dead, pulse;

    always_comb begin
        run          = enable && (state_q != ST_IDLE);
        dead         = (state_q == ST_DEAD);
        pulse        = (state_q == ST_BLANK) || (state_q == ST_ON);
        blank_active = run && (state_q == ST_BLANK);
    end

    // Leg g owns phase g: high side on from dead-time end of its own phase to
    // dead-time end of the other; low side pulses in the other phase.
    for (genvar g = 0; g < NLEG; g++) begin : g_leg
        localparam logic OWN = 1'(g);
        always_comb begin
            hi[g] = run && ((phase_q == OWN) ^ dead);
            lo[g] = run && (phase_q != OWN) && pulse && !peak_trip;
            sr[g] = run && (phase_q == OWN);
        end
    end

    AST_LEG_A_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(hi[0] && lo[0])); // R4
    AST_LEG_B_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(hi[1] && lo[1])); // R4
    AST_BLANK_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (($rose(lo[0]) || $rose(lo[1])) && blank_nz) |-> blank_active); // R6
endmodule

// File: rtl/zvs_bridge_seq.sv
module zvs_bridge_seq
    import zvs_seq_pkg::*;
#(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [CNT_W-1:0] cfg_period,
    input  logic [CNT_W-1:0] cfg_dead,
    input  logic [CNT_W-1:0] cfg_resdly,
    input  logic [CNT_W-1:0] cfg_blank,
    input  logic             pwm_trip,
    input  logic             peak_trip,
    output logic             hi_a,
    output logic             hi_b,
    output logic             lo_a,
    output logic             lo_b,
    output logic             sr_a,
    output logic             sr_b,
    output logic             blank_active
);
    localparam int NLEG = 2;

    logic [CNT_W-1:0] per_q, dead_q, res_q, blank_q;
    logic             load, phase_q;
    seq_state_e       state_q;
    logic [NLEG-1:0]  hi, lo, sr;

    zvs_cfg_latch #(.CNT_W(CNT_W)) cfg_i (
        .clk(clk), .rst_n(rst_n), .load(load),
        .cfg_period(cfg_period), .cfg_dead(cfg_dead),
        .cfg_resdly(cfg_resdly), .cfg_blank(cfg_blank),
        .per_q(per_q), .dead_q(dead_q), .res_q(res_q), .blank_q(blank_q)
    );

    zvs_phase_fsm #(.CNT_W(CNT_W)) fsm_i (
        .clk(clk), .rst_n(rst_n), .enable(enable),
        .pwm_trip(pwm_trip), .peak_trip(peak_trip),
        .per_q(per_q), .dead_q(dead_q), .res_q(res_q), .blank_q(blank_q),
        .state_q(state_q), .phase_q(phase_q), .load(load)
    );

    zvs_gate_decode #(.NLEG(NLEG)) dec_i (
        .clk(clk), .rst_n(rst_n), .enable(enable), .peak_trip(peak_trip),
        .state_q(state_q), .phase_q(phase_q), .blank_nz(blank_q != '0),
        .hi(hi), .lo(lo), .sr(sr), .blank_active(blank_active)
    );

    assign hi_a = hi[0];
    assign hi_b = hi[1];
    assign lo_a = lo[0];
    assign lo_b = lo[1];
    assign sr_a = sr[0];
    assign sr_b = sr[1];
endmodule

// File: tb/zvs_bridge_seq_tb.sv
`timescale 1ns/1ps
module zvs_bridge_seq_tb_top;
    localparam int CNT_W = 10;

    logic clk = 1'b0;
    logic rst_n, enable, pwm_trip, peak_trip;
    logic [CNT_W-1:0] cfg_period, cfg_dead, cfg_resdly, cfg_blank;
    logic hi_a, hi_b, lo_a, lo_b, sr_a, sr_b, blank_active;

    always #4 clk = ~clk;  // 125 MHz

    zvs_bridge_seq #(.CNT_W(CNT_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .enable(enable),
        .cfg_period(cfg_period), .cfg_dead(cfg_dead),
        .cfg_resdly(cfg_resdly), .cfg_blank(cfg_blank),
        .pwm_trip(pwm_trip), .peak_trip(peak_trip),
        .hi_a(hi_a), .hi_b(hi_b), .lo_a(lo_a), .lo_b(lo_b),
        .sr_a(sr_a), .sr_b(sr_b), .blank_active(blank_active)
    );

    int    n_chk = 0;
    int    n_err = 0;
    string cur_tag = "R11";
    bit    done = 1'b0;

    // Reference timeline kept from the requirements
    bit m_run = 1'b0, m_ph = 1'b0, m_done = 1'b0;
    int m_t = 0, mP = 2, mD = 1, mR = 1, mB = 0;

    task automatic chk(string sig, logic act, logic exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%0b expected=%0b at %0t", cur_tag, sig, act, exp, $time);
        end
    endtask

    function automatic int clampv(int v, int lo);
        return (v < lo) ? lo : v;
    endfunction

    task automatic m_load();  // R8 sampling points, R10 clamps
        mP = clampv(int'(cfg_period), 2);
        mD = clampv(int'(cfg_dead), 1);
        mR = clampv(int'(cfg_resdly), 1);
        mB = int'(cfg_blank);
    endtask

    task automatic compare();
        bit ro, dead, act, blank;
        ro    = m_run && (enable === 1'b1);
        dead  = (m_t < mD);
        act   = !m_done && (m_t >= mD + mR);
        blank = act && (m_t < mD + mR + mB);
        chk("hi_a", hi_a, ro && ((!m_ph && !dead) || (m_ph && dead)));
        chk("hi_b", hi_b, ro && ((m_ph && !dead) || (!m_ph && dead)));
        chk("lo_a", lo_a, ro && m_ph && act && !peak_trip);
        chk("lo_b", lo_b, ro && !m_ph && act && !peak_trip);
        chk("sr_a", sr_a, ro && !m_ph);
        chk("sr_b", sr_b, ro && m_ph);
        chk("blank_active", blank_active, ro && blank);
        // R4: no shoot-through on either leg
        chk("R4 leg A overlap", hi_a & lo_a, 1'b0);
        chk("R4 leg B overlap", hi_b & lo_b, 1'b0);
    endtask

    task automatic m_update();
        if (!rst_n || !enable) begin
            m_run = 1'b0;
        end else if (!m_run) begin
            m_run = 1'b1; m_t = 0; m_ph = 1'b0; m_done = 1'b0; m_load();
        end else if (m_t == mP - 1) begin
            if (m_ph) m_load();
            m_ph = !m_ph; m_t = 0; m_done = 1'b0;
        end else begin
            if (!m_done && m_t >= mD + mR)
                if (peak_trip || (pwm_trip && m_t >= mD + mR + mB)) m_done = 1'b1;
            m_t++;
        end
    endtask

    task automatic step();
        #2;
        compare();
        @(posedge clk);
        m_update();
        @(negedge clk);
    endtask

    task automatic set_cfg(int p, int d, int r, int b);
        cfg_period = CNT_W'(p);
        cfg_dead   = CNT_W'(d);
        cfg_resdly = CNT_W'(r);
        cfg_blank  = CNT_W'(b);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_2024));
        rst_n = 1'b0; enable = 1'b1; pwm_trip = 1'b0; peak_trip = 1'b0;
        set_cfg(12, 2, 3, 2);
        @(negedge clk);

        cur_tag = "R11";                   // reset holds outputs low
        repeat (3) step();
        rst_n = 1'b1; enable = 1'b0;
        cur_tag = "R9";
        repeat (2) step();

        cur_tag = "R1"; enable = 1'b1;     // phase structure and sync
        repeat (48) step();

        cur_tag = "R2"; set_cfg(16, 4, 2, 3);  // uppers ignore trips
        for (int i = 0; i < 64; i++) begin
            pwm_trip = 1'($urandom_range(0, 1)); peak_trip = ($urandom_range(0, 9) == 0);
            step();
        end
        pwm_trip = 1'b0; peak_trip = 1'b0;

        cur_tag = "R3"; set_cfg(14, 1, 5, 0);  // resonant delay, max duty
        repeat (56) step();

        cur_tag = "R5"; set_cfg(20, 2, 3, 2);
        for (int i = 0; i < 120; i++) begin
            pwm_trip = ($urandom_range(0, 9) < 3);
            step();
        end

        cur_tag = "R6"; set_cfg(18, 2, 2, 6); pwm_trip = 1'b1;  // trip held high
        repeat (72) step();
        set_cfg(18, 2, 2, 0);                  // blanking disabled
        repeat (72) step();
        pwm_trip = 1'b0;

        cur_tag = "R7"; set_cfg(16, 2, 2, 4);
        for (int i = 0; i < 160; i++) begin
            peak_trip = ($urandom_range(0, 9) == 0);
            step();
        end
        peak_trip = 1'b0;

        cur_tag = "R8";                        // writes at arbitrary cycles
        for (int i = 0; i < 200; i++) begin
            if ($urandom_range(0, 3) == 0)
                set_cfg($urandom_range(2, 24), $urandom_range(1, 6),
                        $urandom_range(1, 6), $urandom_range(0, 6));
            step();
        end

        cur_tag = "R9"; set_cfg(12, 2, 2, 1);
        for (int i = 0; i < 200; i++) begin
            enable = ($urandom_range(0, 19) != 0);
            pwm_trip = ($urandom_range(0, 4) == 0);
            step();
        end
        enable = 1'b1; pwm_trip = 1'b0;

        cur_tag = "R10"; set_cfg(0, 0, 0, 0);  // all-zero settings
        repeat (24) step();
        set_cfg(1, 0, 0, 0);
        repeat (24) step();
        set_cfg(8, 0, 3, 0);
        repeat (32) step();

        cur_tag = "R5";                        // mixed random run
        for (int i = 0; i < 2000; i++) begin
            if ($urandom_range(0, 15) == 0)
                set_cfg($urandom_range(0, 30), $urandom_range(0, 8),
                        $urandom_range(0, 8), $urandom_range(0, 8));
            pwm_trip  = ($urandom_range(0, 9) < 2);
            peak_trip = ($urandom_range(0, 49) == 0);
            enable    = ($urandom_range(0, 99) != 0);
            step();
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule